// File: doc/BRIEF.md
# Paced Multi-Channel Issue Scheduler

This block decides, every clock cycle, which transfer channel of a multi-channel copy engine may issue its next bus transfer. Each channel names where its transfer requests come from through a 6-bit source code: one of the external request lines from peripherals, one of the internal fractional-rate pacing timers, or a constant request for unpaced copies. Every request pulse from the selected source adds one unit of credit to that channel. A channel competes for issue only while it is busy, enabled and holds credit. Each grant spends one unit of credit.

Channels flagged as high priority are favoured. In one scheduling round, every ready high-priority channel is served once. After that, exactly one low-priority channel is served, and then a new round begins. Inside each class the grant rotates, starting after the channel that class granted last. Priority changes only the order of issue. When any channel is eligible, a grant is always given, so a low-priority channel loses no throughput when the scheduler is not saturated.

Each pacing timer holds a 16-bit numerator X and a 16-bit denominator Y, with X no greater than Y. It emits requests at X/Y of the clock rate.

Top module: `dma_issue_sched`

## Requirements
- R1: `grant` has at most one bit set in every cycle, and it is all zero while `rst_n` is low.
- R2: A channel is granted only when its `ch_busy` and `ch_en` bits are both high and its credit is non-zero.
- R3: A channel's credit rises by one for each request pulse from its selected source while the channel is enabled, and falls by one when the channel is granted. Credit saturates at 2^CRED_W-1 (7 by default), so extra requests at the maximum are lost.
- R4: A source code from 0 to 58 selects `ext_req[code]`. Code 63 (0x3F) requests in every cycle.
- R5: Source codes 59 to 62 (0x3B to 0x3E) select pacing timers 0 to 3. A code that names a timer at or above NTMR never requests.
- R6: Each timer adds X to a 16-bit accumulator every cycle. When the sum is Y or more, the timer subtracts Y and emits one request in that cycle. Over n cycles starting from accumulator zero, it therefore emits floor(n*X/Y) requests.
- R7: A timer whose numerator X is 0 never emits a request.
- R8: Inside a round, every eligible high-priority channel that has not yet been served in that round is granted before any low-priority channel. Granting one low-priority channel ends the round. If only already-served high-priority channels are eligible, a new round starts with one of them.
- R9: Within a class, the grant goes to the first eligible channel after the one that class granted last, counting upward and wrapping around. After reset, the search for both classes starts at channel 0.
- R10: Whenever at least one channel is eligible, some channel is granted.
- R11: `grant` follows the current `ch_busy`, `ch_en` and `ch_hi` in the same cycle. A request sampled at a clock edge becomes usable credit in the cycle after that edge.
- R12: While `ch_en` is low, a channel gains no credit from its source and is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_busy | input | NCH | Channel has transfers left to issue |
| ch_en | input | NCH | Channel enable |
| ch_hi | input | NCH | Channel is in the high-priority class |
| ch_src | input | NCH*6 | Per-channel 6-bit request source code; channel c occupies bits [6c+5:6c] |
| ext_req | input | 59 | External request lines from peripherals |
| tmr_num | input | NTMR*FRAC_W | Timer numerators X; timer t occupies bits [16t+15:16t] |
| tmr_den | input | NTMR*FRAC_W | Timer denominators Y; same packing as `tmr_num` |
| grant | output | NCH | One-hot issue grant for this cycle |

## Verification
The assertions check in every cycle that the grant is one-hot or empty, that it goes only to eligible channels, and that the scheduler never idles while a channel is eligible. They also check that saturated credit is kept, that a zero-rate timer stays silent, and, through a shadow record of served channels kept in the checker, that no low-priority grant passes an unserved ready high-priority channel. Only the bench scenarios can show the exact rotation order, the long-run fractional rate of a timer, the count of credits kept across a saturation, the one-cycle lag from request to grant, and that absent timers and disabled channels accumulate nothing. The bench shows these by comparing every cycle against its own behavioural model.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  localparam int SEL_W   = 6;
  localparam int EXT_N   = 59;
  localparam int TMR_MAX = 4;
  localparam logic [SEL_W-1:0] TMR_BASE   = 6'h3B;
  localparam logic [SEL_W-1:0] SEL_ALWAYS = 6'h3F;

  typedef enum logic [1:0] {
    SRC_EXT,
    SRC_TMR,
    SRC_ALWAYS
  } src_kind_e;

  // Classify a source code
  function automatic src_kind_e sel_kind(logic [SEL_W-1:0] sel);
    if (sel == SEL_ALWAYS)   return SRC_ALWAYS;
    else if (sel >= TMR_BASE) return SRC_TMR;
    else                     return SRC_EXT;
  endfunction

  function automatic logic [1:0] sel_tmr_idx(logic [SEL_W-1:0] sel);
    logic [SEL_W-1:0] d;
    d = sel - TMR_BASE;
    return d[1:0];
  endfunction

  // Request presented by the chosen source this cycle
  function automatic logic src_request(logic [SEL_W-1:0] sel,
                                       logic [63:0] ext,
                                       logic [TMR_MAX-1:0] tp);
    case (sel_kind(sel))
      SRC_ALWAYS: return 1'b1;
      SRC_TMR:    return tp[sel_tmr_idx(sel)];
      default:    return ext[sel];
    endcase
  endfunction

endpackage

// File: rtl/dma_frac_timer.sv
module dma_frac_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         pulse
);

  // Returns {pulse, next accumulator}
  function automatic logic [W:0] frac_next(logic [W-1:0] a,
                                           logic [W-1:0] x,
                                           logic [W-1:0] y);
    logic [W:0] s;
    logic       p;
    s = {1'b0, a} + {1'b0, x};
    p = (x != '0) && (s >= {1'b0, y});
    if (p) s = s - {1'b0, y};
    return {p, s[W-1:0]};
  endfunction

  logic [W-1:0] acc;
  logic [W:0]   step;

  assign step  = frac_next(acc, num, den);
  assign pulse = step[W];

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= step[W-1:0];
  end

endmodule

// File: rtl/dma_credit.sv
module dma_credit #(
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nz,
  output logic full
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_step(logic [CW-1:0] c,
                                             logic up, logic dn);
    case ({up, dn})
      2'b10:   return (c == CMAX) ? c : c + 1'b1;
      2'b01:   return (c == '0) ? c : c - 1'b1;
      default: return c;
    endcase
  endfunction

  logic [CW-1:0] cnt;

  assign nz   = (cnt != '0);
  assign full = (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= sat_step(cnt, inc, dec);
  end

endmodule

// File: rtl/dma_round_arb.sv
module dma_round_arb #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] elig,
  input  logic [N-1:0] hi,
  output logic [N-1:0] grant
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST_INIT = IW'(N - 1);

  typedef enum logic [1:0] {PK_NONE, PK_HI, PK_LO, PK_NEWRND} pick_e;

  function automatic logic [N-1:0] rr_pick(logic [N-1:0] m, logic [IW-1:0] last);
    logic [N-1:0] r;
    logic         found;
    int           idx;
    r = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!found && m[idx]) begin
        r[idx] = 1'b1;
        found  = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] oh_idx(logic [N-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (oh[i]) r = r | IW'(i);
    return r;
  endfunction

  logic [N-1:0]  served;
  logic [IW-1:0] last_hi, last_lo;
  logic [N-1:0]  hi_cand, lo_cand, hi_fresh;
  pick_e         mode;

  assign hi_cand  = elig & hi;
  assign lo_cand  = elig & ~hi;
  assign hi_fresh = hi_cand & ~served;

  always_comb begin
    grant = '0;
    mode  = PK_NONE;
    if (|hi_fresh) begin
      grant = rr_pick(hi_fresh, last_hi);
      mode  = PK_HI;
    end else if (|lo_cand) begin
      grant = rr_pick(lo_cand, last_lo);
      mode  = PK_LO;
    end else if (|hi_cand) begin
      grant = rr_pick(hi_cand, last_hi);
      mode  = PK_NEWRND;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      served  <= '0;
      last_hi <= LAST_INIT;
      last_lo <= LAST_INIT;
    end else begin
      case (mode)
        PK_HI: begin
          served  <= served | grant;
          last_hi <= oh_idx(grant);
        end
        PK_LO: begin
          served  <= '0;
          last_lo <= oh_idx(grant);
        end
        PK_NEWRND: begin
          served  <= grant;
          last_hi <= oh_idx(grant);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_issue_sched.sv
module dma_issue_sched
  import dma_sched_pkg::*;
#(
  parameter int NCH    = 12,
  parameter int NTMR   = 4,
  parameter int CRED_W = 3,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           ch_busy,
  input  logic [NCH-1:0]           ch_en,
  input  logic [NCH-1:0]           ch_hi,
  input  logic [NCH*SEL_W-1:0]     ch_src,
  input  logic [EXT_N-1:0]         ext_req,
  input  logic [NTMR*FRAC_W-1:0]   tmr_num,
  input  logic [NTMR*FRAC_W-1:0]   tmr_den,
  output logic [NCH-1:0]           grant
);

  logic [TMR_MAX-1:0] tmr_pulse;
  logic [63:0]        ext_pad;
  logic [NCH-1:0]     inc_v;
  logic [NCH-1:0]     cred_nz;
  logic [NCH-1:0]     cred_full;
  logic [NCH-1:0]     elig;

  assign ext_pad = {{(64-EXT_N){1'b0}}, ext_req};

  for (genvar t = 0; t < TMR_MAX; t++) begin : g_tmr
    if (t < NTMR) begin : g_on
      dma_frac_timer #(.W(FRAC_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .num   (tmr_num[t*FRAC_W +: FRAC_W]),
        .den   (tmr_den[t*FRAC_W +: FRAC_W]),
        .pulse (tmr_pulse[t])
      );
    end else begin : g_off
      assign tmr_pulse[t] = 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign inc_v[c] = ch_en[c] & src_request(ch_src[c*SEL_W +: SEL_W], ext_pad, tmr_pulse);

    dma_credit #(.CW(CRED_W)) u_cred (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_v[c]),
      .dec   (grant[c]),
      .nz    (cred_nz[c]),
      .full  (cred_full[c])
    );
  end

  assign elig = ch_busy & ch_en & cred_nz;

  dma_round_arb #(.N(NCH)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .hi    (ch_hi),
    .grant (grant)
  );

endmodule

// File: rtl/dma_issue_sched_chk.sv
module dma_issue_sched_chk #(
  parameter int NCH    = 12,
  parameter int NTMR   = 4,
  parameter int FRAC_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         ch_busy,
  input logic [NCH-1:0]         ch_en,
  input logic [NCH-1:0]         ch_hi,
  input logic [NCH-1:0]         grant,
  input logic [NCH-1:0]         inc_v,
  input logic [NCH-1:0]         cred_nz,
  input logic [NCH-1:0]         cred_full,
  input logic [3:0]             tmr_pulse,
  input logic [NTMR*FRAC_W-1:0] tmr_num
);

  logic [NCH-1:0] ready;
  logic [NCH-1:0] seen;

  assign ready = ch_busy & ch_en & cred_nz;

  // Shadow record of high-priority channels served in the current round
  always_ff @(posedge clk) begin
    if (!rst_n)                   seen <= '0;
    else if (|(grant & ~ch_hi))   seen <= '0;
    else if (|(grant & seen))     seen <= grant;
    else                          seen <= seen | grant;
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~ready) == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cred_full & inc_v & ~grant) & ~cred_full) == '0));

  p_hi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & ~ch_hi)) |-> ((ready & ch_hi & ~seen) == '0));

  p_no_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready) |-> (|grant));

  for (genvar t = 0; t < NTMR && t < 4; t++) begin : g_zr
    p_zero_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_num[t*FRAC_W +: FRAC_W] == '0) |-> !tmr_pulse[t]);
  end

endmodule

bind dma_issue_sched dma_issue_sched_chk #(
  .NCH(NCH), .NTMR(NTMR), .FRAC_W(FRAC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_busy   (ch_busy),
  .ch_en     (ch_en),
  .ch_hi     (ch_hi),
  .grant     (grant),
  .inc_v     (inc_v),
  .cred_nz   (cred_nz),
  .cred_full (cred_full),
  .tmr_pulse (tmr_pulse),
  .tmr_num   (tmr_num)
);

// File: tb/dma_issue_sched_test.sv
module dma_issue_sched_test;

  localparam int NCH  = 12;
  localparam int NT   = 2;
  localparam int CW   = 3;
  localparam int FW   = 16;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] busy = '0, en = '0, hi = '0;
  logic [5:0] sel_a [NCH];
  logic [NCH*6-1:0] src_flat;
  logic [58:0] ext = '0;
  int xnum [NT];
  int yden [NT];
  logic [NT*FW-1:0] num_flat, den_flat;
  logic [NCH-1:0] grant;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) src_flat[c*6 +: 6] = sel_a[c];
    for (int t = 0; t < NT; t++) begin
      num_flat[t*FW +: FW] = xnum[t][FW-1:0];
      den_flat[t*FW +: FW] = yden[t][FW-1:0];
    end
  end

  dma_issue_sched #(.NCH(NCH), .NTMR(NT), .CRED_W(CW), .FRAC_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .ch_busy(busy), .ch_en(en), .ch_hi(hi),
    .ch_src(src_flat), .ext_req(ext), .tmr_num(num_flat), .tmr_den(den_flat),
    .grant(grant)
  );

  int total = 0, bad = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference state
  int m_cred [NCH];
  int m_acc  [NT];
  bit m_served [NCH];
  int m_last_hi, m_last_lo;
  int last_gi;
  int gcount [NCH];

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rr(logic [NCH-1:0] m, int last);
    for (int k = 1; k <= NCH; k++) if (m[(last + k) % NCH]) return (last + k) % NCH;
    return -1;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin m_cred[c] = 0; m_served[c] = 0; end
    for (int t = 0; t < NT; t++) m_acc[t] = 0;
    m_last_hi = NCH - 1;
    m_last_lo = NCH - 1;
  endtask

  task automatic clear_counts();
    for (int c = 0; c < NCH; c++) gcount[c] = 0;
  endtask

  // One cycle: compare with the model, advance it, move to next falling edge
  task automatic tick();
    bit pl [NT];
    bit rq [NCH];
    logic [NCH-1:0] el, hc, lc, hf;
    int g, mode, s;
    logic [NCH-1:0] expv;
    #1;
    for (int t = 0; t < NT; t++) begin
      s = m_acc[t] + xnum[t];
      pl[t] = (xnum[t] != 0) && (s >= yden[t]);
    end
    for (int c = 0; c < NCH; c++) begin
      s = sel_a[c];
      if (s == 63) rq[c] = 1;
      else if (s >= 59) rq[c] = (s - 59 < NT) ? pl[s - 59] : 0;
      else rq[c] = ext[s];
      el[c] = busy[c] && en[c] && (m_cred[c] > 0);
      hc[c] = el[c] && hi[c];
      lc[c] = el[c] && !hi[c];
      hf[c] = hc[c] && !m_served[c];
    end
    mode = 0;
    g = -1;
    if (|hf) begin g = rr(hf, m_last_hi); mode = 1; end
    else if (|lc) begin g = rr(lc, m_last_lo); mode = 2; end
    else if (|hc) begin g = rr(hc, m_last_hi); mode = 3; end
    expv = (g >= 0) ? (NCH'(1) << g) : '0;
    check(grant === expv, tag, int'(grant), int'(expv));
    last_gi = -1;
    for (int c = 0; c < NCH; c++) if (grant[c]) begin last_gi = c; gcount[c]++; end
    for (int c = 0; c < NCH; c++) begin
      s = m_cred[c] + ((en[c] && rq[c]) ? 1 : 0) - ((c == g) ? 1 : 0);
      m_cred[c] = (s > CMAX) ? CMAX : s;
    end
    for (int t = 0; t < NT; t++) begin
      s = m_acc[t] + xnum[t];
      if (pl[t]) s = s - yden[t];
      m_acc[t] = s & 16'hFFFF;
    end
    if (mode == 1) begin m_served[g] = 1; m_last_hi = g; end
    else if (mode == 2) begin
      for (int c = 0; c < NCH; c++) m_served[c] = 0;
      m_last_lo = g;
    end else if (mode == 3) begin
      for (int c = 0; c < NCH; c++) m_served[c] = (c == g);
      m_last_hi = g;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    tag = "R2";
    busy = '1; en = '1; hi = '0; ext = '0;
    for (int c = 0; c < NCH; c++) sel_a[c] = 6'd58;
    repeat (100) tick();
    busy = '0; en = '0;
  endtask

  initial begin
    int seq [9];
    int lo_n, hi_n;
    for (int c = 0; c < NCH; c++) sel_a[c] = 6'd58;
    for (int t = 0; t < NT; t++) begin xnum[t] = 0; yden[t] = 1; end
    clear_counts();
    repeat (4) @(negedge clk);
    #1;
    check(grant == '0, "R1", int'(grant), 0);
    model_reset();
    rst_n = 1'b1;

    // R9: rotation among low-priority channels, starting at channel 0
    tag = "R9";
    for (int c = 0; c < 4; c++) sel_a[c] = 6'h3F;
    busy = 12'h00F; en = 12'h00F;
    for (int i = 0; i < 9; i++) begin tick(); seq[i] = last_gi; end
    check(seq[0] == -1, "R11", seq[0], -1);
    for (int i = 1; i < 9; i++) check(seq[i] == (i - 1) % 4, "R9", seq[i], (i - 1) % 4);
    drain();

    // R8: two high channels, two low channels, all permanently requesting
    tag = "R8";
    for (int c = 0; c < 4; c++) sel_a[c] = 6'h3F;
    busy = 12'h00F; en = 12'h00F; hi = 12'h003;
    tick();
    clear_counts();
    repeat (30) tick();
    lo_n = gcount[2] + gcount[3];
    hi_n = gcount[0] + gcount[1];
    check(lo_n == 10, "R8", lo_n, 10);
    check(hi_n == 20, "R10", hi_n, 20);
    drain();

    // R4 / R11: external line 20 on channel 5
    tag = "R4";
    sel_a[5] = 6'd20; busy = 12'h020; en = 12'h020;
    ext[20] = 1'b1;
    tick();
    check(last_gi == -1, "R11", last_gi, -1);
    ext[20] = 1'b0;
    tick();
    check(last_gi == 5, "R11", last_gi, 5);
    clear_counts();
    for (int i = 0; i < 30; i++) begin
      ext[20] = (i % 5 == 0);
      ext[21] = 1'b1;
      tick();
    end
    ext = '0;
    tick();
    check(gcount[5] == 6, "R4", gcount[5], 6);
    drain();

    // R6: timer 0 at rate 3/7
    tag = "R6";
    xnum[0] = 3; yden[0] = 7;
    sel_a[6] = 6'h3B; busy = 12'h040; en = 12'h040;
    clear_counts();
    repeat (350) tick();
    check(gcount[6] >= 149 && gcount[6] <= 151, "R6", gcount[6], 150);
    xnum[0] = 0;
    drain();

    // R7: zero numerator stays silent
    tag = "R7";
    yden[0] = 7;
    sel_a[6] = 6'h3B; busy = 12'h040; en = 12'h040;
    clear_counts();
    repeat (100) tick();
    check(gcount[6] == 0, "R7", gcount[6], 0);

    // R5: code 0x3D names timer 2, absent with two timers
    tag = "R5";
    xnum[1] = 1; yden[1] = 1;
    sel_a[7] = 6'h3D; busy = 12'h080; en = 12'h080;
    clear_counts();
    repeat (100) tick();
    check(gcount[7] == 0, "R5", gcount[7], 0);
    xnum[1] = 0;
    drain();

    // R3: saturation at seven credits
    tag = "R3";
    sel_a[8] = 6'h3F; busy = '0; en = 12'h100;
    repeat (20) tick();
    sel_a[8] = 6'd58; busy = 12'h100;
    clear_counts();
    repeat (20) tick();
    check(gcount[8] == CMAX, "R3", gcount[8], CMAX);
    drain();

    // R12: disabled channel gains nothing and is never granted
    tag = "R12";
    sel_a[9] = 6'h3F; busy = 12'h200; en = '0;
    clear_counts();
    repeat (20) tick();
    sel_a[9] = 6'd58; en = 12'h200;
    repeat (10) tick();
    check(gcount[9] == 0, "R12", gcount[9], 0);

    // R10: mixed random traffic, compared with the model every cycle
    tag = "R10";
    xnum[0] = 5; yden[0] = 9; xnum[1] = 1; yden[1] = 4;
    for (int c = 0; c < NCH; c++) begin
      case (c % 6)
        0: sel_a[c] = 6'd1;
        1: sel_a[c] = 6'd2;
        2: sel_a[c] = 6'h3B;
        3: sel_a[c] = 6'h3C;
        4: sel_a[c] = 6'h3F;
        default: sel_a[c] = 6'h3E;
      endcase
    end
    for (int i = 0; i < 400; i++) begin
      busy = NCH'($urandom);
      en   = NCH'($urandom) | NCH'($urandom);
      if (i % 16 == 0) hi = NCH'($urandom);
      ext[1] = $urandom_range(0, 1);
      ext[2] = $urandom_range(0, 1);
      tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule